// File: doc/BRIEF.md
# Pending MSI Vector Scan Engine

This block services message-signalled interrupt groups in hardware. Each group has a summary register and a set of index registers. A set summary bit shows that the matching index register holds pending vector bits, and reading an index register clears it. When a group raises its request line, the engine reads that group's summary. It then walks the set summary bits from the lowest upward. For each one it reads the index register once and streams out the global number of every pending vector bit, lowest bit first.

The global vector number interleaves the groups: number = ((index * VEC_PER_IDX) + bit) * NUM_GROUPS + group. When the engine has used up its local copy of the summary, it reads the summary again, so that vectors posted during the scan are not missed. It ends a group's service only when such a read returns zero. Several requesting groups are served one at a time in rotating order. Register reads use a request pulse, and the engine waits for a read-valid return that arrives a fixed number of cycles later.

Top module: `msi_vec_scan_engine`

## Requirements
- R1: After reset the engine is idle: busy, vec_valid, rd_req and done are all low, and they stay low while no group is being served.
- R2: The first read of every service is a summary read (rd_sum=1) of the accepted group. The summary value is taken from rd_data bits [IDX_PER_GROUP-1:0], where bit x set means index register x is pending.
- R3: Index registers are serviced in ascending index order, and each one is read exactly once per summary snapshot (rd_sum=0, rd_idx names the register).
- R4: The set bits of an index register are emitted from lowest to highest, each as vec_num = ((index*VEC_PER_IDX)+bit)*NUM_GROUPS + group.
- R5: While vec_valid is high and vec_ready is low, vec_valid stays high and vec_num holds its value. No vector is lost or repeated.
- R6: Once the local summary copy is empty, the summary is read again. Service continues if that read is non-zero and ends only on a zero read, so vectors posted during a scan are delivered in the same service.
- R7: At most one register read is outstanding. After rd_req the engine issues no further request until rd_valid returns.
- R8: Among requesting groups, the next one served is the first at or above the group after the one last served, wrapping around. The first service after reset starts the search from group 0.
- R9: done is a one-cycle pulse with done_grp naming the group served. busy is high from acceptance through the done cycle and low in the cycle after.
- R10: A group whose first summary read returns zero completes with done and emits no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_req | input | NUM_GROUPS | Per-group service request, level |
| rd_req | output | 1 | One-cycle register read request |
| rd_sum | output | 1 | 1: summary register read, 0: index register read |
| rd_grp | output | clog2(NUM_GROUPS) | Group being served (read address) |
| rd_idx | output | clog2(IDX_PER_GROUP) | Index register address for index reads |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | VEC_PER_IDX | Read return data |
| vec_valid | output | 1 | Vector output valid |
| vec_ready | input | 1 | Vector output ready |
| vec_num | output | clog2(NUM_GROUPS*IDX_PER_GROUP*VEC_PER_IDX) | Global vector number |
| busy | output | 1 | A group is being served |
| done | output | 1 | One-cycle end-of-service pulse |
| done_grp | output | clog2(NUM_GROUPS) | Group whose service ended |

## Verification
The hardest case to reach from the ports is a vector posted into a group after its summary snapshot was taken but before the service ends. That vector must arrive only through the final summary read. The bench holds a register-bank model with read-to-clear index registers. It waits for the first vector handshake of a service and then posts a new bit into a lower index register that was idle at snapshot time. It then expects that vector last, after three summary reads. Rotating order is checked by loading three groups while their requests are masked and releasing them together. Output stalls come from a pseudo-random ready pattern.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM_REQ,
        ST_SUM_WAIT,
        ST_IDX_REQ,
        ST_IDX_WAIT,
        ST_EMIT,
        ST_DONE
    } scan_st_e;

endpackage

// File: rtl/msi_lowbit_pick.sv
module msi_lowbit_pick #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Descending walk so that the lowest set bit is the last writer.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/msi_rr_arbiter.sv
module msi_rr_arbiter #(
    parameter int N  = 16,
    localparam int GW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [GW-1:0] ptr,
    output logic          any,
    output logic [GW-1:0] pick
);
    logic [N-1:0] rot;

    // Rotate the request vector so that position 0 is the pointer group.
    for (genvar g = 0; g < N; g++) begin : g_rot
        always_comb rot[g] = req[(int'(ptr) + g) % N];
    end

    logic       found;
    logic [GW-1:0] off;

    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && rot[i]) begin
                found = 1'b1;
                off   = GW'(i);
            end
        end
    end

    assign any  = found;
    assign pick = GW'((int'(ptr) + int'(off)) % N);
endmodule

// File: rtl/msi_vec_scan_engine.sv
module msi_vec_scan_engine
    import msi_scan_pkg::*;
#(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int VEC_PER_IDX   = 16,
    localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int IW = (IDX_PER_GROUP > 1) ? $clog2(IDX_PER_GROUP) : 1,
    localparam int BW = (VEC_PER_IDX > 1) ? $clog2(VEC_PER_IDX) : 1,
    localparam int VW = $clog2(NUM_GROUPS * IDX_PER_GROUP * VEC_PER_IDX)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_GROUPS-1:0]  grp_req,
    output logic                   rd_req,
    output logic                   rd_sum,
    output logic [GW-1:0]          rd_grp,
    output logic [IW-1:0]          rd_idx,
    input  logic                   rd_valid,
    input  logic [VEC_PER_IDX-1:0] rd_data,
    output logic                   vec_valid,
    input  logic                   vec_ready,
    output logic [VW-1:0]          vec_num,
    output logic                   busy,
    output logic                   done,
    output logic [GW-1:0]          done_grp
);

    typedef struct packed {
        scan_st_e                 st;
        logic [GW-1:0]            grp;
        logic [GW-1:0]            ptr;
        logic [IDX_PER_GROUP-1:0] sum;
        logic [IW-1:0]            idx;
        logic [VEC_PER_IDX-1:0]   bits;
    } scan_regs_t;

    scan_regs_t r_d, r_q;

    logic          arb_any;
    logic [GW-1:0] arb_pick;
    logic          sum_any;
    logic [IW-1:0] sum_idx;
    logic          bit_any;
    logic [BW-1:0] bit_idx;
    logic [IDX_PER_GROUP-1:0] sum_after;

    msi_rr_arbiter #(.N(NUM_GROUPS)) arb_i (
        .req  (grp_req),
        .ptr  (r_q.ptr),
        .any  (arb_any),
        .pick (arb_pick)
    );

    msi_lowbit_pick #(.W(IDX_PER_GROUP)) sum_pick_i (
        .vec (r_q.sum),
        .any (sum_any),
        .idx (sum_idx)
    );

    msi_lowbit_pick #(.W(VEC_PER_IDX)) bit_pick_i (
        .vec (r_q.bits),
        .any (bit_any),
        .idx (bit_idx)
    );

    always_comb begin
        sum_after = r_q.sum;
        sum_after[r_q.idx] = 1'b0;
    end

    always_comb begin
        r_d       = r_q;
        rd_req    = 1'b0;
        rd_sum    = 1'b0;
        vec_valid = 1'b0;
        done      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arb_any) begin
                    r_d.grp = arb_pick;
                    r_d.ptr = (arb_pick == GW'(NUM_GROUPS - 1)) ? '0 : GW'(arb_pick + 1'b1);
                    r_d.st  = ST_SUM_REQ;
                end
            end
            ST_SUM_REQ: begin
                rd_req = 1'b1;
                rd_sum = 1'b1;
                r_d.st = ST_SUM_WAIT;
            end
            ST_SUM_WAIT: begin
                if (rd_valid) begin
                    r_d.sum = rd_data[IDX_PER_GROUP-1:0];
                    r_d.st  = (|rd_data[IDX_PER_GROUP-1:0]) ? ST_IDX_REQ : ST_DONE;
                end
            end
            ST_IDX_REQ: begin
                rd_req  = 1'b1;
                r_d.idx = sum_idx;
                r_d.st  = ST_IDX_WAIT;
            end
            ST_IDX_WAIT: begin
                if (rd_valid) begin
                    r_d.bits = rd_data;
                    r_d.st   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (bit_any) begin
                    vec_valid = 1'b1;
                    if (vec_ready) r_d.bits[bit_idx] = 1'b0;
                end else begin
                    r_d.sum = sum_after;
                    r_d.st  = (|sum_after) ? ST_IDX_REQ : ST_SUM_REQ;
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_grp   = r_q.grp;
    assign rd_idx   = sum_idx;
    assign vec_num  = VW'((int'(r_q.idx) * VEC_PER_IDX + int'(bit_idx)) * NUM_GROUPS
                          + int'(r_q.grp));
    assign busy     = (r_q.st != ST_IDLE);
    assign done_grp = r_q.grp;

endmodule

// File: rtl/msi_scan_checker.sv
module msi_scan_checker #(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int VEC_PER_IDX   = 16,
    localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int VW = $clog2(NUM_GROUPS * IDX_PER_GROUP * VEC_PER_IDX)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_sum,
    input logic [GW-1:0] rd_grp,
    input logic          rd_valid,
    input logic          vec_valid,
    input logic          vec_ready,
    input logic [VW-1:0] vec_num,
    input logic          busy,
    input logic          done
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        outst_q <= 1'b0;
        else if (rd_req)   outst_q <= 1'b1;
        else if (rd_valid) outst_q <= 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!vec_valid && !rd_req && !done)); // R1
    AST_START_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rd_req && rd_sum)); // R2
    AST_VEC_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((int'(vec_num) % NUM_GROUPS) == int'(rd_grp))); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_num))); // R5
    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !outst_q); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R9
endmodule

bind msi_vec_scan_engine msi_scan_checker #(
    .NUM_GROUPS    (NUM_GROUPS),
    .IDX_PER_GROUP (IDX_PER_GROUP),
    .VEC_PER_IDX   (VEC_PER_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_sum    (rd_sum),
    .rd_grp    (rd_grp),
    .rd_valid  (rd_valid),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_num   (vec_num),
    .busy      (busy),
    .done      (done)
);

// File: tb/msi_vec_scan_engine_tb_top.sv
`timescale 1ns/1ps
module msi_vec_scan_engine_tb_top;
    localparam int NG  = 16;
    localparam int NI  = 8;
    localparam int NV  = 16;
    localparam int LAT = 3;

    typedef struct packed {
        logic [3:0]  g;
        logic [2:0]  ia;
        logic [15:0] ma;
        logic [2:0]  ib;
        logic [15:0] mb;
    } load_t;

    localparam int NT = 6;
    localparam load_t TBL [NT] = '{
        '{4'd0,  3'd0, 16'h0001, 3'd7, 16'h8000},
        '{4'd15, 3'd3, 16'h00F0, 3'd3, 16'h0100},
        '{4'd7,  3'd6, 16'hA005, 3'd1, 16'h0002},
        '{4'd3,  3'd4, 16'hFFFF, 3'd4, 16'h0000},
        '{4'd12, 3'd5, 16'h0810, 3'd0, 16'h4000},
        '{4'd10, 3'd2, 16'h8001, 3'd5, 16'h0400}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NG-1:0] grp_req;
    logic          rd_req, rd_sum, rd_valid;
    logic [3:0]    rd_grp;
    logic [2:0]    rd_idx;
    logic [15:0]   rd_data;
    logic          vec_valid, vec_ready;
    logic [10:0]   vec_num;
    logic          busy, done;
    logic [3:0]    done_grp;

    msi_vec_scan_engine dut_i (
        .clk(clk), .rst_n(rst_n), .grp_req(grp_req),
        .rd_req(rd_req), .rd_sum(rd_sum), .rd_grp(rd_grp), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_num(vec_num),
        .busy(busy), .done(done), .done_grp(done_grp)
    );

    // Register bank model: read-to-clear index registers, fixed latency.
    logic [15:0] mem [NG][NI];
    logic [NG-1:0] gate, force_req, bank_req;
    logic        inj_en;
    logic [3:0]  inj_g;
    logic [2:0]  inj_i;
    logic [15:0] inj_m;
    logic [15:0] bank_rdata;
    logic        pv [LAT];
    logic [15:0] pd [LAT];

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            bank_req[g] = 1'b0;
            for (int i = 0; i < NI; i++) bank_req[g] = bank_req[g] | (|mem[g][i]);
        end
        grp_req = (bank_req & gate) | force_req;
        bank_rdata = '0;
        if (rd_sum) begin
            for (int i = 0; i < NI; i++) bank_rdata[i] = |mem[rd_grp][i];
        end else begin
            bank_rdata = mem[rd_grp][rd_idx];
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) begin pv[k] <= 1'b0; pd[k] <= '0; end
            for (int g = 0; g < NG; g++)
                for (int i = 0; i < NI; i++) mem[g][i] <= '0;
        end else begin
            pv[0] <= rd_req;
            pd[0] <= bank_rdata;
            for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pd[k] <= pd[k-1]; end
            if (rd_req && !rd_sum) mem[rd_grp][rd_idx] <= '0;
            if (inj_en) mem[inj_g][inj_i] <= mem[inj_g][inj_i] | inj_m;
        end
    end
    assign rd_valid = pv[LAT-1];
    assign rd_data  = pd[LAT-1];

    logic [7:0] lf = 8'h5A;
    logic       stall_en = 1'b0;
    always @(posedge clk) lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    assign vec_ready = stall_en ? lf[0] : 1'b1;

    // Monitor, sampling at the falling edge.
    int rec [64];
    int rec_cnt = 0, sum_reads = 0, idx_reads = 0, done_cnt = 0;
    int done_list [8];
    int stall_bad = 0, ovl_bad = 0, busy_bad = 0, start_bad = 0;
    bit outst = 0, prev_stall = 0, prev_done = 0, prev_busy = 0;
    int prev_num = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(vec_valid && int'(vec_num) == prev_num)) stall_bad++;
            prev_stall = vec_valid && !vec_ready;
            prev_num   = int'(vec_num);
            if (vec_valid && vec_ready && rec_cnt < 64) begin
                rec[rec_cnt] = int'(vec_num);
                rec_cnt++;
            end
            if (rd_valid) outst = 0;
            if (rd_req) begin
                if (outst) ovl_bad++;
                outst = 1;
                if (rd_sum) sum_reads++; else idx_reads++;
            end
            if (busy && !prev_busy && !(rd_req && rd_sum)) start_bad++;
            if (done) begin
                if (!busy) busy_bad++;
                if (done_cnt < 8) done_list[done_cnt] = int'(done_grp);
                done_cnt++;
            end
            if (prev_done && busy) busy_bad++;
            prev_done = done;
            prev_busy = busy;
        end
    end

    int errors = 0, checks = 0;
    int expv [64];
    int exp_cnt = 0;
    logic [15:0] exp_mem [NG][NI];

    task automatic chk(input bit ok, input string req, input int act, input int expct);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expct);
        end
    endtask

    task automatic finish_sim();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 0);
        finish_sim();
    end

    task automatic inject(input int g, input int i, input logic [15:0] m);
        @(posedge clk); #1;
        inj_en = 1'b1; inj_g = 4'(g); inj_i = 3'(i); inj_m = m;
        exp_mem[g][i] = exp_mem[g][i] | m;
        @(posedge clk); #1;
        inj_en = 1'b0;
    endtask

    task automatic add_exp(input int g);
        for (int i = 0; i < NI; i++) begin
            for (int b = 0; b < NV; b++) begin
                if (exp_mem[g][i][b]) begin
                    expv[exp_cnt] = ((i * NV) + b) * NG + g;
                    exp_cnt++;
                end
            end
            exp_mem[g][i] = '0;
        end
    endtask

    task automatic clear_counts();
        @(posedge clk); #1;
        rec_cnt = 0; sum_reads = 0; idx_reads = 0; done_cnt = 0;
        stall_bad = 0; ovl_bad = 0; busy_bad = 0; start_bad = 0;
        exp_cnt = 0;
    endtask

    task automatic wait_done(input int n);
        while (done_cnt < n) @(posedge clk);
        #1;
    endtask

    task automatic cmp_vecs(input string tag);
        chk(rec_cnt == exp_cnt, {"R4 vector count ", tag}, rec_cnt, exp_cnt);
        for (int k = 0; k < exp_cnt && k < rec_cnt; k++)
            chk(rec[k] == expv[k], {"R4 vector order/number ", tag}, rec[k], expv[k]);
    endtask

    task automatic cmp_side(input string tag);
        chk(stall_bad == 0, {"R5 stall hold ", tag}, stall_bad, 0);
        chk(ovl_bad == 0, {"R7 one outstanding read ", tag}, ovl_bad, 0);
        chk(busy_bad == 0, {"R9 busy/done ", tag}, busy_bad, 0);
        chk(start_bad == 0, {"R2 summary read first ", tag}, start_bad, 0);
    endtask

    initial begin
        gate = '0; force_req = '0; inj_en = 1'b0; inj_g = '0; inj_i = '0; inj_m = '0;
        for (int g = 0; g < NG; g++)
            for (int i = 0; i < NI; i++) exp_mem[g][i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(vec_valid == 1'b0, "R1 vec_valid in reset", int'(vec_valid), 0);
        chk(rd_req == 1'b0, "R1 rd_req in reset", int'(rd_req), 0);
        chk(done == 1'b0, "R1 done in reset", int'(done), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && rd_req == 1'b0, "R1 idle after reset", int'(busy), 0);

        // Table walk: one group per entry; odd entries with random stalls.
        for (int k = 0; k < NT; k++) begin
            int nidx;
            clear_counts();
            stall_en = k[0];
            inject(int'(TBL[k].g), int'(TBL[k].ia), TBL[k].ma);
            inject(int'(TBL[k].g), int'(TBL[k].ib), TBL[k].mb);
            nidx = (TBL[k].ia == TBL[k].ib || TBL[k].mb == 16'h0) ? 1 : 2;
            add_exp(int'(TBL[k].g));
            gate = '1;
            wait_done(1);
            gate = '0;
            repeat (2) @(posedge clk);
            cmp_vecs("table");
            chk(done_list[0] == int'(TBL[k].g), "R9 done_grp", done_list[0], int'(TBL[k].g));
            chk(sum_reads == 2, "R6 summary reads", sum_reads, 2);
            chk(idx_reads == nidx, "R3 one read per index register", idx_reads, nidx);
            cmp_side("table");
        end
        stall_en = 1'b0;

        // R6: vector posted mid-scan into an index idle at snapshot time.
        clear_counts();
        inject(3, 2, 16'h0022);
        inject(3, 5, 16'h0001);
        add_exp(3);
        gate = '1;
        while (rec_cnt < 1) @(posedge clk);
        inject(3, 0, 16'h0080);
        exp_mem[3][0] = '0;
        expv[exp_cnt] = 7 * NG + 3;
        exp_cnt++;
        wait_done(1);
        gate = '0;
        repeat (2) @(posedge clk);
        cmp_vecs("re-read R6");
        chk(sum_reads == 3, "R6 summary re-read count", sum_reads, 3);
        chk(idx_reads == 3, "R3 index reads with re-read", idx_reads, 3);
        cmp_side("re-read");

        // R8: rotating order; pointer now sits after group 3.
        clear_counts();
        inject(2, 1, 16'h0004);
        inject(6, 7, 16'h0100);
        inject(13, 4, 16'h0003);
        add_exp(6);
        add_exp(13);
        add_exp(2);
        gate = '1;
        wait_done(3);
        gate = '0;
        repeat (2) @(posedge clk);
        chk(done_list[0] == 6, "R8 first served", done_list[0], 6);
        chk(done_list[1] == 13, "R8 second served", done_list[1], 13);
        chk(done_list[2] == 2, "R8 wrap served", done_list[2], 2);
        cmp_vecs("round-robin R8");
        cmp_side("round-robin");

        // R10: request from a group with nothing pending.
        clear_counts();
        force_req = 16'h0040;
        wait_done(1);
        force_req = '0;
        repeat (4) @(posedge clk);
        chk(rec_cnt == 0, "R10 no vector on empty group", rec_cnt, 0);
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        chk(done_list[0] == 6, "R10 done_grp", done_list[0], 6);
        chk(sum_reads == 1, "R10 single summary read", sum_reads, 1);
        chk(idx_reads == 0, "R10 no index read", idx_reads, 0);
        @(negedge clk);
        chk(busy == 1'b0 && vec_valid == 1'b0, "R1 idle at end", int'(busy), 0);

        finish_sim();
    end
endmodule